// File: doc/BRIEF.md
# Peripheral Bus Cycle Sequencer with Timeout

This block sits between a host-side register decoder and a synchronous peripheral bus that serves up to four plug-in modules. The host raises a request level together with a space code, a slot number, a byte address and write data. The sequencer brings the request into the peripheral clock domain and drives one select strobe to the addressed module for one clock. It then waits for that module's acknowledge and hands read data back to the host. The host holds the request until it sees completion, and then withdraws it.

Each module may insert wait states before it acknowledges. A counter that starts with the select strobe ends any access that is never acknowledged. A control bit decides how that access ends. It either completes toward the host with filler data, or it is reported as a bus error so the host can fault the cycle. Every timeout sets a sticky status flag that software clears explicitly. When a module acknowledges, a one-cycle activity pulse is produced for that slot, which can feed an indicator stretcher.

Top module: `pbus_seq`

## Requirements
- R1: A request is passed through a two-stage synchroniser. When the request rises in the clock cycle before edge 1, the select strobe is first high in the cycle after edge 3.
- R2: Each access asserts a select strobe for exactly one clock cycle, and only once.
- R3: Exactly one select line of one slot is active at a time. The space code chooses the vector (0 = I/O, 1 = ID, 2 = memory, 3 = interrupt) and the slot number chooses the bit within it.
- R4: During the select cycle the bus address equals host byte address bits [7:1], and the write flag and write data match the request. A module acknowledge completes the access with the module's read data. The acknowledge is registered once before use, so with w wait states completion appears 3+w cycles after the select cycle.
- R5: If no registered acknowledge is seen by the 8th clock counted from the select cycle, the access ends by timeout. Its completion or error appears 8 cycles after the select cycle.
- R6: Control bit 4 selects how a timeout ends. When the bit is 0, the access completes with read data 16'hFFFF. When it is 1, only the bus-error output rises. Completion and bus error are never high together.
- R7: Status bit 5 is set by any timeout and stays set. Writing 1 to bit 5 clears it, and writing 0 to bit 5 leaves it unchanged. Bit 4 reads back the control value. Bits 7:6 and 3:0 read 0.
- R8: Reads in the ID space return only the low data byte, with the upper byte forced to 0.
- R9: A module-acknowledged access produces a one-cycle pulse on that slot's activity output. A timed-out access produces none.
- R10: Completion or bus error stays high until the request is withdrawn. An acknowledge that arrives after a timeout has no effect.
- R11: After reset no select, completion, bus error or activity output is high, and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock (8 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| hst_req_i | input | 1 | Host request level, held until completion is seen |
| hst_we_i | input | 1 | 1 = write access |
| hst_space_i | input | 2 | Space code: 0 I/O, 1 ID, 2 memory, 3 interrupt |
| hst_slot_i | input | 2 | Target module slot |
| hst_addr_i | input | 8 | Host byte address |
| hst_wdata_i | input | 16 | Write data |
| hst_done_o | output | 1 | Access completed (level) |
| hst_berr_o | output | 1 | Access ended in bus error (level) |
| hst_rdata_o | output | 16 | Read data returned to host |
| cfg_wr_i | input | 1 | Status/control register write strobe |
| cfg_wdata_i | input | 8 | Status/control write data |
| cfg_rdata_o | output | 8 | Status/control read value |
| pb_io_sel_o | output | 4 | I/O-space select, one bit per slot |
| pb_id_sel_o | output | 4 | ID-space select, one bit per slot |
| pb_mem_sel_o | output | 4 | Memory-space select, one bit per slot |
| pb_int_sel_o | output | 4 | Interrupt-space select, one bit per slot |
| pb_we_o | output | 1 | Bus write flag |
| pb_addr_o | output | 7 | Bus word address |
| pb_wdata_o | output | 16 | Bus write data |
| pb_rdata_i | input | 16 | Bus read data from modules |
| pb_ack_i | input | 4 | Per-slot module acknowledge |
| act_o | output | 4 | Per-slot one-cycle activity pulse |

## Verification
Suppose the synchroniser or sequencer state is wrong. The select strobe then shows up off its three-cycle offset, lasts longer than one cycle, or lands on the wrong line. The bench sees this in the select cycle itself. A faulty wait counter moves the completion cycle away from 3+w or 8. The bench compares that distance directly, so an early or late timeout shows at once, and a w=5 access separates a counter that is off by one from a correct one. Damaged status bookkeeping shows up on the next status read, which the bench makes right after each timeout and after each write-one-to-clear.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    localparam int NSLOT      = 4;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int DW         = 16;
    localparam int HAW        = 8;
    localparam int PAW        = HAW - 1;
    localparam int CFG_W      = 8;
    localparam int STRICT_BIT = 4;
    localparam int TMO_BIT    = 5;
    localparam int LANE_W     = 8;
    localparam int TMO_DEF    = 8;

    typedef enum logic [1:0] {
        SP_IO  = 2'd0,
        SP_ID  = 2'd1,
        SP_MEM = 2'd2,
        SP_INT = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              we;
        space_e            sp;
        logic [SLOT_W-1:0] slot;
        logic [PAW-1:0]    addr;
        logic [DW-1:0]     wdata;
    } xfer_t;

    function automatic xfer_t pack_xfer(input logic we, input logic [1:0] sp,
                                        input logic [SLOT_W-1:0] slot,
                                        input logic [HAW-1:0] byte_addr,
                                        input logic [DW-1:0] wdata);
        xfer_t x;
        x.we    = we;
        x.sp    = space_e'(sp);
        x.slot  = slot;
        x.addr  = byte_addr[HAW-1:1];
        x.wdata = wdata;
        return x;
    endfunction

    // ID space carries one byte per word: upper lane forced to zero
    function automatic logic [DW-1:0] shape_rdata(input space_e sp, input logic [DW-1:0] raw);
        logic [DW-1:0] r;
        r = raw;
        if (sp == SP_ID) r[DW-1:LANE_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pbseq_timer.sv
module pbseq_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                                  cnt <= '0;
        else if (start_i)                         cnt <= CW'(1);
        else if (run_i && (cnt < CW'(LIMIT)))     cnt <= cnt + CW'(1);
    end

    assign expire_o = run_i && (cnt == CW'(LIMIT - 1));

    // R5: the counter never runs past its limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(LIMIT));
endmodule

// File: rtl/pbseq_stat.sv
module pbseq_stat
    import pbseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             tmo_evt_i,
    output logic             strict_o,
    output logic [CFG_W-1:0] rdata_o
);
    logic flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            strict_o <= 1'b0;
            flag     <= 1'b0;
        end else begin
            if (wr_i) strict_o <= wdata_i[STRICT_BIT];
            if (tmo_evt_i)                   flag <= 1'b1;
            else if (wr_i && wdata_i[TMO_BIT]) flag <= 1'b0;
        end
    end

    always_comb begin
        rdata_o             = '0;
        rdata_o[STRICT_BIT] = strict_o;
        rdata_o[TMO_BIT]    = flag;
    end

    // R7: a timeout always leaves the sticky flag set
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst) tmo_evt_i |=> flag);
endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
    import pbseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_s_i,
    input  xfer_t         xfer_i,
    input  logic          ack_hit_i,
    input  logic [DW-1:0] rdata_q_i,
    input  logic          expire_i,
    input  logic          strict_i,
    output xfer_t         cur_o,
    output logic          sel_on_o,
    output logic          start_o,
    output logic          run_o,
    output logic          done_o,
    output logic          berr_o,
    output logic [DW-1:0] rdata_o,
    output logic          tmo_evt_o,
    output logic          act_evt_o
);
    seq_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_o   <= '0;
            done_o  <= 1'b0;
            berr_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_s_i) begin
                    cur_o <= xfer_i;
                    st    <= ST_SEL;
                end
                ST_SEL: st <= ST_WAIT;
                ST_WAIT: begin
                    if (ack_hit_i) begin
                        rdata_o <= shape_rdata(cur_o.sp, rdata_q_i);
                        done_o  <= 1'b1;
                        st      <= ST_DONE;
                    end else if (expire_i) begin
                        if (strict_i) begin
                            berr_o <= 1'b1;
                        end else begin
                            done_o  <= 1'b1;
                            rdata_o <= '1;
                        end
                        st <= ST_DONE;
                    end
                end
                ST_DONE: if (!req_s_i) begin
                    done_o <= 1'b0;
                    berr_o <= 1'b0;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sel_on_o  = (st == ST_SEL);
    assign start_o   = (st == ST_SEL);
    assign run_o     = (st == ST_WAIT);
    assign tmo_evt_o = (st == ST_WAIT) && !ack_hit_i && expire_i;
    assign act_evt_o = (st == ST_WAIT) && ack_hit_i;

    // R2: select lasts one cycle
    a_r2_sel_one_cycle: assert property (@(posedge clk) disable iff (rst) sel_on_o |=> !sel_on_o);
    // R1: select only follows a synchronised request
    a_r1_sel_after_req: assert property (@(posedge clk) disable iff (rst) $rose(sel_on_o) |-> $past(req_s_i));
    // R10: completion held while request stays high
    a_r10_hold: assert property (@(posedge clk) disable iff (rst) (done_o && req_s_i) |=> done_o);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbseq_pkg::*;
#(
    parameter int TMO_CLKS = TMO_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req_i,
    input  logic              hst_we_i,
    input  logic [1:0]        hst_space_i,
    input  logic [SLOT_W-1:0] hst_slot_i,
    input  logic [HAW-1:0]    hst_addr_i,
    input  logic [DW-1:0]     hst_wdata_i,
    output logic              hst_done_o,
    output logic              hst_berr_o,
    output logic [DW-1:0]     hst_rdata_o,
    input  logic              cfg_wr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [CFG_W-1:0]  cfg_rdata_o,
    output logic [NSLOT-1:0]  pb_io_sel_o,
    output logic [NSLOT-1:0]  pb_id_sel_o,
    output logic [NSLOT-1:0]  pb_mem_sel_o,
    output logic [NSLOT-1:0]  pb_int_sel_o,
    output logic              pb_we_o,
    output logic [PAW-1:0]    pb_addr_o,
    output logic [DW-1:0]     pb_wdata_o,
    input  logic [DW-1:0]     pb_rdata_i,
    input  logic [NSLOT-1:0]  pb_ack_i,
    output logic [NSLOT-1:0]  act_o
);
    logic             req_s;
    logic [NSLOT-1:0] ack_q;
    logic [DW-1:0]    rdata_q;
    xfer_t            cur;
    logic             sel_on, t_start, t_run, expire, strict;
    logic             tmo_evt, act_evt;

    pbseq_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i(hst_req_i), .q_o(req_s)
    );

    // acknowledge and data sampled one clock late
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= '0;
            rdata_q <= '0;
        end else begin
            ack_q   <= pb_ack_i;
            rdata_q <= pb_rdata_i;
        end
    end

    pbseq_fsm u_fsm (
        .clk(clk), .rst(rst), .req_s_i(req_s),
        .xfer_i(pack_xfer(hst_we_i, hst_space_i, hst_slot_i, hst_addr_i, hst_wdata_i)),
        .ack_hit_i(ack_q[cur.slot]), .rdata_q_i(rdata_q), .expire_i(expire),
        .strict_i(strict), .cur_o(cur), .sel_on_o(sel_on), .start_o(t_start),
        .run_o(t_run), .done_o(hst_done_o), .berr_o(hst_berr_o),
        .rdata_o(hst_rdata_o), .tmo_evt_o(tmo_evt), .act_evt_o(act_evt)
    );

    pbseq_timer #(.LIMIT(TMO_CLKS)) u_timer (
        .clk(clk), .rst(rst), .start_i(t_start), .run_i(t_run), .expire_o(expire)
    );

    pbseq_stat u_stat (
        .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
        .tmo_evt_i(tmo_evt), .strict_o(strict), .rdata_o(cfg_rdata_o)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hit;
        assign hit             = sel_on && (cur.slot == SLOT_W'(g));
        assign pb_io_sel_o[g]  = hit && (cur.sp == SP_IO);
        assign pb_id_sel_o[g]  = hit && (cur.sp == SP_ID);
        assign pb_mem_sel_o[g] = hit && (cur.sp == SP_MEM);
        assign pb_int_sel_o[g] = hit && (cur.sp == SP_INT);

        always_ff @(posedge clk) begin
            if (rst) act_o[g] <= 1'b0;
            else     act_o[g] <= act_evt && (cur.slot == SLOT_W'(g));
        end
    end

    assign pb_we_o    = cur.we;
    assign pb_addr_o  = cur.addr;
    assign pb_wdata_o = cur.wdata;

    // R3: at most one select line anywhere
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pb_io_sel_o, pb_id_sel_o, pb_mem_sel_o, pb_int_sel_o}));
    // R6: completion and bus error exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst) !(hst_done_o && hst_berr_o));
    // R9: activity pulse lasts one cycle
    a_r9_act_pulse: assert property (@(posedge clk) disable iff (rst) (|act_o) |=> !(|act_o));
endmodule

// File: tb/pbus_seq_tb_top.sv
module pbus_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req_i = 1'b0, hst_we_i = 1'b0;
    logic [1:0]  hst_space_i = '0, hst_slot_i = '0;
    logic [7:0]  hst_addr_i = '0;
    logic [15:0] hst_wdata_i = '0;
    logic        hst_done_o, hst_berr_o;
    logic [15:0] hst_rdata_o;
    logic        cfg_wr_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0, cfg_rdata_o;
    logic [3:0]  pb_io_sel_o, pb_id_sel_o, pb_mem_sel_o, pb_int_sel_o;
    logic        pb_we_o;
    logic [6:0]  pb_addr_o;
    logic [15:0] pb_wdata_o;
    logic [15:0] pb_rdata_i = '0;
    logic [3:0]  pb_ack_i = '0;
    logic [3:0]  act_o;

    pbus_seq dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct { bit berr; logic [15:0] rd; int lat; } exp_t;
    exp_t sb_q[$];

    // module model and expectations
    int   ws[4];
    bit   present[4];
    int   req_cyc, sel_cyc;
    int   e_idx;
    bit   e_we;
    logic [6:0]  e_addr;
    logic [15:0] e_wd;
    int   act_cnt[4];

    function automatic logic [15:0] model_rd(int slot, int sp, logic [6:0] pa);
        return {4'hB, 2'(slot), 2'(sp), 1'b1, pa};
    endfunction

    logic [15:0] selv, selv_prev = '0;
    logic [3:0]  act_prev = '0;
    bit          fin_prev = 0;

    always @(negedge clk) begin
        selv = {pb_int_sel_o, pb_mem_sel_o, pb_id_sel_o, pb_io_sel_o};
        if (!rst) begin
            if (|selv) begin
                chk(selv_prev == '0, "R2 select longer than one cycle", selv, 0);
                sel_cyc = cyc;
                chk(cyc - req_cyc == 3, "R1 request-to-select cycles", cyc - req_cyc, 3);
                chk(selv == (16'h1 << e_idx), "R3 select line", selv, 16'h1 << e_idx);
                chk(pb_addr_o == e_addr && pb_we_o == e_we && (!e_we || pb_wdata_o == e_wd),
                    "R4 bus address/write fields", {pb_we_o, pb_addr_o}, {e_we, e_addr});
                begin
                    automatic int sl = e_idx % 4;
                    automatic int w  = ws[sl];
                    automatic logic [15:0] d = model_rd(sl, e_idx / 4, pb_addr_o);
                    if (present[sl]) fork
                        begin
                            repeat (1 + w) @(negedge clk);
                            pb_ack_i[sl] = 1'b1;
                            pb_rdata_i   = d;
                            @(negedge clk);
                            pb_ack_i[sl] = 1'b0;
                        end
                    join_none
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (act_o[i] && act_prev[i]) chk(0, "R9 activity pulse width", 2, 1);
                if (act_o[i] && !act_prev[i]) act_cnt[i]++;
            end
            if ((hst_done_o || hst_berr_o) && !fin_prev) begin
                if (sb_q.size() == 0) chk(0, "R4 unexpected completion", 1, 0);
                else begin
                    automatic exp_t e = sb_q.pop_front();
                    chk(hst_berr_o == e.berr && hst_done_o == !e.berr, "R6 completion kind",
                        {hst_done_o, hst_berr_o}, {!e.berr, e.berr});
                    if (!e.berr) chk(hst_rdata_o == e.rd, "R4/R8 read data", hst_rdata_o, e.rd);
                    chk(cyc - sel_cyc == e.lat, "R5 completion latency", cyc - sel_cyc, e.lat);
                end
            end
        end
        selv_prev = selv;
        act_prev  = act_o;
        fin_prev  = hst_done_o || hst_berr_o;
    end

    task automatic acc(input bit we, input int sp, input int slot, input logic [7:0] addr,
                       input logic [15:0] wd, input int w, input bit pres, input bit exp_berr,
                       input bit exp_fill, input int hold, input int exp_act);
        exp_t e;
        automatic int a0 = act_cnt[slot];
        ws[slot] = w; present[slot] = pres;
        e_idx = sp * 4 + slot; e_we = we; e_addr = addr[7:1]; e_wd = wd;
        e.berr = exp_berr;
        e.rd   = exp_fill ? 16'hFFFF : model_rd(slot, sp, addr[7:1]);
        if (sp == 1 && !exp_fill) e.rd[15:8] = 8'h00;
        e.lat  = (pres && w <= 5) ? 3 + w : 8;
        sb_q.push_back(e);
        @(negedge clk);
        hst_we_i = we; hst_space_i = 2'(sp); hst_slot_i = 2'(slot);
        hst_addr_i = addr; hst_wdata_i = wd; hst_req_i = 1'b1; req_cyc = cyc;
        while (!(hst_done_o || hst_berr_o)) @(negedge clk);
        repeat (hold) @(negedge clk);
        if (hold > 0) chk(hst_done_o || hst_berr_o, "R10 completion held", 0, 1);
        hst_req_i = 1'b0;
        while (hst_done_o || hst_berr_o) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(act_cnt[slot] - a0 == exp_act, "R9 activity pulse count", act_cnt[slot] - a0, exp_act);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = v;
        @(negedge clk); cfg_wr_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk({pb_io_sel_o, pb_id_sel_o, pb_mem_sel_o, pb_int_sel_o} == '0 && !hst_done_o &&
            !hst_berr_o && act_o == '0 && cfg_rdata_o == '0, "R11 reset state",
            {hst_done_o, hst_berr_o, cfg_rdata_o}, 0);
        // R4 zero wait I/O read, slot 0
        acc(0, 0, 0, 8'h12, 16'h0, 0, 1, 0, 0, 0, 1);
        // R4 memory write with two wait states, slot 1
        acc(1, 2, 1, 8'h5B, 16'hC3A5, 2, 1, 0, 0, 0, 1);
        // R5 boundary: five wait states still succeed, interrupt space, slot 3
        acc(0, 3, 3, 8'h07, 16'h0, 5, 1, 0, 0, 0, 1);
        // R8 ID read keeps only low byte, slot 2
        acc(0, 1, 2, 8'h23, 16'h0, 1, 1, 0, 0, 2, 1);
        chk(cfg_rdata_o == 8'h00, "R7 no flag without timeout", cfg_rdata_o, 8'h00);
        // R5/R6 six wait states time out, forced completion with filler; late ack ignored (R10)
        acc(0, 0, 3, 8'h40, 16'h0, 6, 1, 0, 1, 3, 0);
        chk(cfg_rdata_o == 8'h20, "R7 flag set by timeout", cfg_rdata_o, 8'h20);
        cfg_write(8'h00);
        chk(cfg_rdata_o == 8'h20, "R7 writing 0 leaves flag", cfg_rdata_o, 8'h20);
        cfg_write(8'h20);
        chk(cfg_rdata_o == 8'h00, "R7 write one clears flag", cfg_rdata_o, 8'h00);
        // R6 strict mode: absent module gives bus error
        cfg_write(8'h10);
        chk(cfg_rdata_o == 8'h10, "R7 control bit readback", cfg_rdata_o, 8'h10);
        acc(1, 2, 2, 8'h7E, 16'h1234, 0, 0, 1, 0, 0, 0);
        chk(cfg_rdata_o == 8'h30, "R7 flag after bus error", cfg_rdata_o, 8'h30);
        cfg_write(8'h20);
        chk(cfg_rdata_o == 8'h00, "R7 clear and leave strict", cfg_rdata_o, 8'h00);
        // R3 remaining lines after clearing
        acc(0, 1, 0, 8'hFF, 16'h0, 0, 1, 0, 0, 0, 1);
        acc(1, 3, 1, 8'h02, 16'h00FF, 3, 1, 0, 0, 0, 1);
        chk(sb_q.size() == 0, "R4 all expected completions seen", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule